// File: doc/BRIEF.md
# Bit-Manipulation and Divide-Step ALU

This block is a 32-bit execution slice for the less common integer operations of a processor pipeline. It takes two operands, a 4-bit operation code and the current condition-code word. After one clock it returns a registered result and a registered condition-code word. The operations are:

- logical and arithmetic shifts that saturate when the amount is out of range;
- a bit test that writes flags;
- an unsigned clamp;
- a leading-zero count;
- three byte- and bit-level permutations;
- an absolute value;
- one step of restoring division.

The pipeline drives `in_valid` together with the operands. The registered outputs change only when a valid operation is presented, and `out_valid` follows one cycle later. Add and subtract flag generation, multiplication and the register file are handled elsewhere.

Top module: `bitops_alu`

## Requirements
- R1: Op 0 (shift left) and op 1 (logical shift right) shift A by the full 32-bit unsigned amount B. Any amount above 31 gives zero.
- R2: Op 2 (arithmetic shift right) shifts A right and fills with A[31]. An amount above 31 gives 0xFFFFFFFF when A[31] is 1, and 0 otherwise.
- R3: Op 3 (bit test) returns A unchanged as the result. It selects bit k = B[4:0] of A. In flags_out, bit 3 equals A[k], and bit 2 is 1 only when A[k:0] is all zero. Bit 4 is cleared, and every other bit copies flags_in.
- R4: Op 4 (clamp) returns B when A > B (unsigned), and A otherwise.
- R5: Op 5 returns the number of leading zero bits of A. For A = 0 it returns 32.
- R6: Op 6 exchanges the upper and lower 16-bit halves of A. Op 7 exchanges the two bytes inside each 16-bit half.
- R7: Op 8 reverses the bit order inside each of the four bytes of A. Byte positions do not change.
- R8: Op 9 returns the two's-complement absolute value of A. 0x80000000 maps to itself.
- R9: Op 10 (divide step) forms T = A shifted left by one, keeping 32 bits. It returns T − B if T ≥ B (unsigned), and T otherwise.
- R10: Codes 11 to 15 return A unchanged. For every op other than 3, flags_out equals flags_in.
- R11: After reset, out_valid, result and flags_out are 0. out_valid equals in_valid one cycle earlier. result and flags_out hold their values in cycles with in_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and op code are valid this cycle |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, or shift amount, bit index or bound |
| flags_in | input | 32 | Current condition-code word |
| out_valid | output | 1 | Registered result is valid |
| result | output | 32 | Registered result |
| flags_out | output | 32 | Registered condition-code word |

## Verification
Shift amounts of 0, 31, exactly 32 and very large values are applied to operands with bit 31 both set and clear. These patterns separate a saturating shifter from one that only uses the low five bits, and show whether the arithmetic fill follows the sign. The bit test is tried with the selected bit set, with only a lower bit set, and with only higher bits set. This separates a Z flag that covers the lower bits from one that looks at the tested bit alone. The permutations use one asymmetric pattern, so each of the three reorderings gives a distinct value. The clamp, absolute value and divide step each include an equality or overflow edge: A equal to B, the most negative number, and T equal to B.

// File: rtl/bmalu_pkg.sv
package bmalu_pkg;

    localparam int DW       = 32;
    localparam int SHW      = $clog2(DW);
    localparam int CNT_W    = SHW + 1;
    localparam int FLAG_X   = 4;
    localparam int FLAG_N   = 3;
    localparam int FLAG_Z   = 2;

    typedef enum logic [3:0] {
        OP_SHL   = 4'd0,
        OP_SHR   = 4'd1,
        OP_SAR   = 4'd2,
        OP_BTST  = 4'd3,
        OP_BOUND = 4'd4,
        OP_CLZ   = 4'd5,
        OP_SWAPH = 4'd6,
        OP_SWAPB = 4'd7,
        OP_REVB  = 4'd8,
        OP_ABS   = 4'd9,
        OP_DSTEP = 4'd10
    } alu_op_e;

    typedef enum logic [1:0] {
        GRP_SHIFT,
        GRP_PERM,
        GRP_ARITH,
        GRP_PASS
    } alu_grp_e;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] res;
        logic [DW-1:0] ccs;
    } alu_out_t;

    function automatic alu_grp_e op_group(input logic [3:0] op);
        case (op)
            OP_SHL, OP_SHR, OP_SAR:                 return GRP_SHIFT;
            OP_CLZ, OP_SWAPH, OP_SWAPB, OP_REVB:    return GRP_PERM;
            OP_BOUND, OP_ABS, OP_DSTEP:             return GRP_ARITH;
            default:                                return GRP_PASS;
        endcase
    endfunction

endpackage

// File: rtl/bmalu_shift.sv
module bmalu_shift
    import bmalu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int AW = $clog2(W);

    logic          over;
    logic [AW-1:0] amt;
    logic [W-1:0]  fill;

    assign amt  = b[AW-1:0];
    assign over = |b[W-1:AW];
    assign fill = {W{a[W-1]}};

    always_comb begin
        case (op)
            OP_SHL:  y = over ? '0   : (a << amt);
            OP_SHR:  y = over ? '0   : (a >> amt);
            OP_SAR:  y = over ? fill : W'($signed(a) >>> amt);
            default: y = a;
        endcase
    end
endmodule

// File: rtl/bmalu_perm.sv
module bmalu_perm
    import bmalu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    localparam int NB   = W / 8;
    localparam int HALF = W / 2;
    localparam int CW   = $clog2(W) + 1;

    logic [W-1:0]  rev_bytes;
    logic [W-1:0]  swap_in_half;
    logic [CW-1:0] lead_zeros;

    genvar gb, gi;
    generate
        for (gb = 0; gb < NB; gb++) begin : g_byte
            for (gi = 0; gi < 8; gi++) begin : g_bit
                assign rev_bytes[8*gb + gi] = a[8*gb + 7 - gi];
            end
            if (gb % 2 == 0) begin : g_lo
                assign swap_in_half[8*gb +: 8] = a[8*(gb+1) +: 8];
            end else begin : g_hi
                assign swap_in_half[8*gb +: 8] = a[8*(gb-1) +: 8];
            end
        end
    endgenerate

    always_comb begin
        logic found;
        found      = 1'b0;
        lead_zeros = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && a[i]) begin
                lead_zeros = CW'(W - 1 - i);
                found      = 1'b1;
            end
        end
    end

    always_comb begin
        case (op)
            OP_CLZ:   y = W'(lead_zeros);
            OP_SWAPH: y = {a[HALF-1:0], a[W-1:HALF]};
            OP_SWAPB: y = swap_in_half;
            OP_REVB:  y = rev_bytes;
            default:  y = a;
        endcase
    end
endmodule

// File: rtl/bmalu_arith.sv
module bmalu_arith
    import bmalu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W-1:0] shifted;
    logic [W-1:0] neg_a;

    assign shifted = {a[W-2:0], 1'b0};
    assign neg_a   = W'(0) - a;

    always_comb begin
        case (op)
            OP_BOUND: y = (a > b) ? b : a;
            OP_ABS:   y = a[W-1] ? neg_a : a;
            OP_DSTEP: y = (shifted >= b) ? (shifted - b) : shifted;
            default:  y = a;
        endcase
    end
endmodule

// File: rtl/bmalu_btest.sv
module bmalu_btest
    import bmalu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] ccs_in,
    output logic [W-1:0] ccs_out
);
    localparam int AW = $clog2(W);

    logic [AW-1:0] idx;
    logic [W-1:0]  low_mask;
    logic          bit_val;
    logic          low_zero;

    assign idx      = b[AW-1:0];
    assign low_mask = {W{1'b1}} >> (AW'(W - 1) - idx);
    assign bit_val  = a[idx];
    assign low_zero = ~|(a & low_mask);

    always_comb begin
        ccs_out         = ccs_in;
        ccs_out[FLAG_X] = 1'b0;
        ccs_out[FLAG_N] = bit_val;
        ccs_out[FLAG_Z] = low_zero;
    end
endmodule

// File: rtl/bitops_alu.sv
module bitops_alu
    import bmalu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [3:0]    op_sel,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic [DW-1:0] flags_in,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic [DW-1:0] flags_out
);
    logic [DW-1:0] y_shift, y_perm, y_arith, ccs_bt;
    logic [DW-1:0] res_d, ccs_d;
    alu_out_t      q;

    bmalu_shift #(.W(DW)) u_shift (.op(op_sel), .a(opnd_a), .b(opnd_b), .y(y_shift));
    bmalu_perm  #(.W(DW)) u_perm  (.op(op_sel), .a(opnd_a), .y(y_perm));
    bmalu_arith #(.W(DW)) u_arith (.op(op_sel), .a(opnd_a), .b(opnd_b), .y(y_arith));
    bmalu_btest #(.W(DW)) u_btest (.a(opnd_a), .b(opnd_b), .ccs_in(flags_in), .ccs_out(ccs_bt));

    always_comb begin
        case (op_group(op_sel))
            GRP_SHIFT: res_d = y_shift;
            GRP_PERM:  res_d = y_perm;
            GRP_ARITH: res_d = y_arith;
            default:   res_d = opnd_a;
        endcase
        ccs_d = (op_sel == OP_BTST) ? ccs_bt : flags_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= in_valid;
            if (in_valid) begin
                q.res <= res_d;
                q.ccs <= ccs_d;
            end
        end
    end

    assign out_valid = q.valid;
    assign result    = q.res;
    assign flags_out = q.ccs;

    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result) && $stable(flags_out));
    a_r1_left_saturates: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == OP_SHL && opnd_b > 32'd31) |=> result == '0);
    a_r3_btst_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == OP_BTST) |=>
            (!flags_out[FLAG_X] && flags_out[1:0] == $past(flags_in[1:0])
             && result == $past(opnd_a)));
    a_r4_clamp_bounded: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == OP_BOUND) |=>
            (result <= $past(opnd_b) && result <= $past(opnd_a)));
    a_r5_clz_range: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == OP_CLZ) |=> result <= 32'd32);
    a_r10_flags_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel != OP_BTST) |=> flags_out == $past(flags_in));
endmodule

// File: tb/bitops_alu_test.sv
module bitops_alu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0, flags_in = '0;
    logic        out_valid;
    logic [31:0] result, flags_out;
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    bitops_alu uut (.clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
                    .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in(flags_in),
                    .out_valid(out_valid), .result(result), .flags_out(flags_out));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] f);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; flags_in = f; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R11 reset result", result, 32'd0);
        chk("R11 reset flags", flags_out, 32'd0);
    endtask

    task automatic t_logical_shifts;
        run(4'd0, 32'h8000_0001, 32'd4, 32'h0);    chk("R1 shl 4", result, 32'h0000_0010);
        run(4'd0, 32'h0000_0001, 32'd31, 32'h0);   chk("R1 shl 31", result, 32'h8000_0000);
        run(4'd0, 32'hFFFF_FFFF, 32'd32, 32'h0);   chk("R1 shl 32", result, 32'h0);
        run(4'd1, 32'h8000_0000, 32'd31, 32'h0);   chk("R1 shr 31", result, 32'h1);
        run(4'd1, 32'hFFFF_FFFF, 32'h0001_0001, 32'h0); chk("R1 shr huge", result, 32'h0);
    endtask

    task automatic t_arith_shift;
        run(4'd2, 32'h8000_0000, 32'd4, 32'h0);    chk("R2 sar 4", result, 32'hF800_0000);
        run(4'd2, 32'h8000_0000, 32'd33, 32'h0);   chk("R2 sar neg sat", result, 32'hFFFF_FFFF);
        run(4'd2, 32'h7FFF_FFFF, 32'd40, 32'h0);   chk("R2 sar pos sat", result, 32'h0);
        run(4'd2, 32'h4000_0000, 32'd0, 32'h0);    chk("R2 sar 0", result, 32'h4000_0000);
    endtask

    // flags: bit4 X, bit3 N, bit2 Z
    task automatic t_bit_test;
        run(4'd3, 32'h0000_0020, 32'd5, 32'hFFFF_FFFF);
        chk("R3 bit set flags", flags_out, 32'hFFFF_FFEB);
        chk("R3 result is A", result, 32'h0000_0020);
        run(4'd3, 32'h0000_0001, 32'd5, 32'h0000_0013);
        chk("R3 lower bit set", flags_out, 32'h0000_0003);
        run(4'd3, 32'hFFFF_FFC0, 32'd5, 32'h0000_0010);
        chk("R3 only higher bits", flags_out, 32'h0000_0004);
        run(4'd3, 32'h8000_0000, 32'h0000_003F, 32'h0);
        chk("R3 index uses low bits", flags_out, 32'h0000_0008);
    endtask

    task automatic t_bound;
        run(4'd4, 32'd100, 32'd50, 32'h0);  chk("R4 clamp", result, 32'd50);
        run(4'd4, 32'd20, 32'd50, 32'h0);   chk("R4 below", result, 32'd20);
        run(4'd4, 32'd50, 32'd50, 32'h0);   chk("R4 equal", result, 32'd50);
        run(4'd4, 32'h8000_0000, 32'd1, 32'h0); chk("R4 unsigned", result, 32'd1);
    endtask

    task automatic t_clz;
        run(4'd5, 32'h0, 32'h0, 32'h0);           chk("R5 zero", result, 32'd32);
        run(4'd5, 32'h8000_0000, 32'h0, 32'h0);   chk("R5 top", result, 32'd0);
        run(4'd5, 32'h0001_FFFF, 32'h0, 32'h0);   chk("R5 mid", result, 32'd15);
        run(4'd5, 32'h0000_0001, 32'h0, 32'h0);   chk("R5 one", result, 32'd31);
    endtask

    task automatic t_permute;
        run(4'd6, 32'h1234_5678, 32'h0, 32'h0); chk("R6 swap halves", result, 32'h5678_1234);
        run(4'd7, 32'h1234_5678, 32'h0, 32'h0); chk("R6 swap bytes", result, 32'h3412_7856);
        run(4'd8, 32'h1234_5678, 32'h0, 32'h0); chk("R7 reverse bits", result, 32'h482C_6A1E);
        run(4'd8, 32'h0180_F00F, 32'h0, 32'h0); chk("R7 reverse edges", result, 32'h8001_0FF0);
    endtask

    task automatic t_abs;
        run(4'd9, 32'hFFFF_FFFB, 32'h0, 32'h0); chk("R8 negative", result, 32'd5);
        run(4'd9, 32'd7, 32'h0, 32'h0);         chk("R8 positive", result, 32'd7);
        run(4'd9, 32'h8000_0000, 32'h0, 32'h0); chk("R8 most negative", result, 32'h8000_0000);
    endtask

    task automatic t_dstep;
        run(4'd10, 32'd5, 32'd10, 32'h0);          chk("R9 equal subtracts", result, 32'd0);
        run(4'd10, 32'd4, 32'd10, 32'h0);          chk("R9 below keeps", result, 32'd8);
        run(4'd10, 32'h8000_0003, 32'd4, 32'h0);   chk("R9 msb dropped", result, 32'd2);
    endtask

    task automatic t_pass_and_flags;
        run(4'd11, 32'hDEAD_BEEF, 32'd1, 32'hA5A5_A5A5);
        chk("R10 code 11 pass", result, 32'hDEAD_BEEF);
        chk("R10 flags untouched", flags_out, 32'hA5A5_A5A5);
        run(4'd15, 32'h0BAD_F00D, 32'd2, 32'h0000_001C);
        chk("R10 code 15 pass", result, 32'h0BAD_F00D);
        run(4'd0, 32'h1, 32'd1, 32'h0000_001F);
        chk("R10 shift keeps flags", flags_out, 32'h0000_001F);
    endtask

    task automatic t_timing;
        @(negedge clk);
        op_sel = 4'd0; opnd_a = 32'h1; opnd_b = 32'd3; flags_in = 32'h7; in_valid = 1'b1;
        @(negedge clk);
        chk("R11 valid after one cycle", {31'd0, out_valid}, 32'd1);
        chk("R11 result after one cycle", result, 32'h8);
        in_valid = 1'b0; opnd_a = 32'hFFFF; flags_in = 32'h0;
        @(negedge clk);
        chk("R11 valid drops", {31'd0, out_valid}, 32'd0);
        chk("R11 result holds", result, 32'h8);
        chk("R11 flags hold", flags_out, 32'h7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_logical_shifts();
        t_arith_shift();
        t_bit_test();
        t_bound();
        t_clz();
        t_permute();
        t_abs();
        t_dstep();
        t_pass_and_flags();
        t_timing();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule